// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-side half of a simple serial port. A processor reaches it through a single-cycle 32-bit register port that decodes word addresses. It holds one received character, the control, baud, FIFO-control and millisecond registers as plain storage, two status registers and a test register, and it drives one combined interrupt line. Baud generation, bit shifting, FIFOs, DMA and modem lines sit outside it.

On the line side, a byte source offers characters with a valid strobe and may flag a line break instead. The block accepts a character only while its one-deep holding register is empty, and it shows this on a ready output. Reading the receive-data register drains the holder.

A transmit write emits the byte on a one-cycle strobe and briefly drops the transmit-ready status flag. Writing control register 2 with its soft-reset bit at zero returns the block to its reset state.

Top module: `uart_regfront`

## Requirements
- R1: Registers are selected by the byte address shifted right by two. The word indices are: receive data 0x00, transmit data 0x10, control 1/2/3 at 0x20/0x21/0x22, FIFO control 0x24, status 1/2 at 0x25/0x26, baud increment 0x29, baud modulator 0x2A, baud count 0x2B, millisecond 0x2C and test 0x2D. Reads return zero in the upper 16 bits. Reads of 0x23, of 0x29 and of any undecoded index return zero.
- R2: After reset the registers read as follows: status 1 = 0x6040 (transmit-ready bit 13, receiver-idle bit 6, RTS-status bit 14), status 2 = 0x4028 (transmit-FIFO-empty bit 14, transmit-complete bit 3, DCD-in bit 5), test = 0x0060 (receive-empty bit 5, transmit-empty bit 6), control 1 = 0, control 2 = 0x0001, control 3 = 0x0700, modulator = 0, baud count = 4, FIFO control = 0, millisecond = 0. The holding register reads 0x4000 (error marker, bit 14).
- R3: Control 1/3, FIFO control, modulator and millisecond keep the low 16 bits of a write. A write to index 0x29 updates the baud count that is read at 0x2B.
- R4: Rx_ready is high exactly while receive-ready (status 1 bit 9) is clear. A valid character is accepted at that point, which sets status 1 bit 9 and status 2 bit 0, clears test bit 5, and stores the byte in bits 7:0 of the holding register. A character offered while the holder is full is dropped.
- R5: A valid offer with the break input high stores the marker 0x0800 (bit 11) instead of the byte, through the same acceptance path.
- R6: A read of receive data returns the holding register. If the holder is full, bit 15 (character ready) is also set, and the same cycle empties the holder. The block then clears status 1 bit 9 and status 2 bit 0, sets test bit 5 and raises rx_ready. A read with the holder empty changes nothing.
- R7: Status 1 clears on write-one only for bits 4, 5, 7, 8, 10, 11, 12 and 15. Status 2 clears on write-one only for bits 1, 2, 4, 6, 7, 8, 10, 11, 12, 13 and 15. Every other status bit, and the whole test register, ignores writes.
- R8: A write to transmit data while control 2 bit 2 is set puts the low byte on tx_byte with tx_strobe high for one cycle. Status 1 bit 13 reads low for that cycle and high after it. With control 2 bit 2 clear, the write has no effect.
- R9: The irq output is high when (status 1 bit 9 and control 1 bit 9) is true. It is also high when control 1 bit 6 is set and either test bit 6 is set or (status 1 bit 13 and control 1 bit 13) is true. With control 1 bit 6 clear, the transmit-ready term is ignored.
- R10: A write to control 2 with bit 0 clear empties the holder. It also restores the reset values of control 1 and 3, the modulator, the baud count, both status registers and the holding register. FIFO control and millisecond keep their values.
- R11: Control 2 stores the low 16 bits of every write with bit 0 forced to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current access (combinational) |
| rx_valid | input | 1 | Line side offers a character |
| rx_byte | input | 8 | Offered character |
| rx_break | input | 1 | The offer is a line break |
| rx_ready | output | 1 | Holder empty; an offer will be accepted |
| tx_strobe | output | 1 | One-cycle transmit byte pulse |
| tx_byte | output | 8 | Byte being transmitted |
| irq | output | 1 | Combined interrupt |

## Verification
A holder whose full flag is wrong shows up in the same cycle on rx_ready. It also corrupts the next receive-data read, either through a missing character-ready bit or through a character that is not drained. A wrong status or control value is visible on the first read of that index, and an interrupt enable that is wired wrongly shows on irq as soon as its condition is set up. A soft reset that misses a register, or that hits the FIFO-control or millisecond storage, appears on the read-back that follows it.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned REG_W = 16;

  // word indices
  localparam int unsigned IX_RXD  = 'h00;
  localparam int unsigned IX_TXD  = 'h10;
  localparam int unsigned IX_CR1  = 'h20;
  localparam int unsigned IX_CR2  = 'h21;
  localparam int unsigned IX_CR3  = 'h22;
  localparam int unsigned IX_CR4  = 'h23;
  localparam int unsigned IX_FCR  = 'h24;
  localparam int unsigned IX_SR1  = 'h25;
  localparam int unsigned IX_SR2  = 'h26;
  localparam int unsigned IX_BINC = 'h29;
  localparam int unsigned IX_BMOD = 'h2A;
  localparam int unsigned IX_BCNT = 'h2B;
  localparam int unsigned IX_MSEC = 'h2C;
  localparam int unsigned IX_TEST = 'h2D;

  // bit positions
  localparam int unsigned C1_EN      = 0;
  localparam int unsigned C1_TXE_IE  = 6;
  localparam int unsigned C1_RRDY_IE = 9;
  localparam int unsigned C1_TRDY_IE = 13;
  localparam int unsigned C2_SRST    = 0;
  localparam int unsigned C2_RXEN    = 1;
  localparam int unsigned C2_TXEN    = 2;
  localparam int unsigned S1_RRDY    = 9;
  localparam int unsigned S1_TRDY    = 13;
  localparam int unsigned S2_RDR     = 0;
  localparam int unsigned T_RXEMPTY  = 5;
  localparam int unsigned T_TXEMPTY  = 6;
  localparam int unsigned RD_CHRDY   = 15;

  localparam logic [REG_W-1:0] S1_W1C   = 16'h9DB0;
  localparam logic [REG_W-1:0] S2_W1C   = 16'hBDD6;
  localparam logic [REG_W-1:0] S1_INIT  = 16'h6040;
  localparam logic [REG_W-1:0] S2_INIT  = 16'h4028;
  localparam logic [REG_W-1:0] CR3_INIT = 16'h0700;
  localparam logic [REG_W-1:0] BCNT_INIT = 16'h0004;
  localparam logic [REG_W-1:0] HOLD_ERR = 16'h4000;
  localparam logic [REG_W-1:0] HOLD_BRK = 16'h0800;

  // interrupt equation
  function automatic logic irq_eval(input logic [REG_W-1:0] sr1,
                                    input logic [REG_W-1:0] cr1,
                                    input logic [REG_W-1:0] tst);
    logic rx_term, tx_term;
    rx_term = sr1[S1_RRDY] & cr1[C1_RRDY_IE];
    tx_term = (sr1[S1_TRDY] & cr1[C1_TRDY_IE]) | tst[T_TXEMPTY];
    return rx_term | (cr1[C1_TXE_IE] & tx_term);
  endfunction

  // write-one-to-clear update
  function automatic logic [REG_W-1:0] w1c(input logic [REG_W-1:0] cur,
                                           input logic [REG_W-1:0] wr,
                                           input logic [REG_W-1:0] mask);
    return cur & ~(wr & mask);
  endfunction
endpackage

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold
  import uart_rf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic             rx_break,
  input  logic             take,
  output logic             full,
  output logic             accept,
  output logic [REG_W-1:0] hold
);
  logic [REG_W-1:0] next_word;

  assign accept    = rx_valid & ~full;
  assign next_word = rx_break ? HOLD_BRK : REG_W'(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= HOLD_ERR;
    end else if (soft_rst) begin
      full <= 1'b0;
      hold <= HOLD_ERR;
    end else if (accept) begin
      full <= 1'b1;
      hold <= next_word;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !soft_rst) |=> full);
  a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !soft_rst && !take) |=> $stable(hold) && full);
  a_r6_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full) |=> !full);
  a_r5_break_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_break && !soft_rst) |=> hold == HOLD_BRK);
endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status
  import uart_rf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_sr1,
  input  logic              wr_sr2,
  input  logic [REG_W-1:0]  wdata,
  input  logic              tx_fire,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [REG_W-1:0]  sr1_q,
  output logic [REG_W-1:0]  sr2_q,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr1_q     <= S1_INIT;
      sr2_q     <= S2_INIT;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else if (soft_rst) begin
      sr1_q     <= S1_INIT;
      sr2_q     <= S2_INIT;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= tx_fire;
      if (tx_fire) begin
        tx_byte        <= tx_data;
        sr1_q[S1_TRDY] <= 1'b0;
      end else if (wr_sr1) begin
        sr1_q <= w1c(sr1_q, wdata, S1_W1C) | (REG_W'(1) << S1_TRDY);
      end else begin
        sr1_q[S1_TRDY] <= 1'b1;
      end
      if (wr_sr2) sr2_q <= w1c(sr2_q, wdata, S2_W1C);
    end
  end

  a_r8_tx_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !soft_rst) |=> (tx_strobe && !sr1_q[S1_TRDY]));
  a_r8_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe && !tx_fire && !soft_rst) |=> sr1_q[S1_TRDY] && !tx_strobe);
  a_r7_protected_sr2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sr2 && !soft_rst) |=> ((sr2_q & ~S2_W1C) == ($past(sr2_q) & ~S2_W1C)));
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sr1,
  input  logic [REG_W-1:0] cr1,
  input  logic [REG_W-1:0] tst,
  output logic             irq
);
  assign irq = irq_eval(sr1, cr1, tst);

  a_r9_masked_tx_term: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cr1[C1_TXE_IE]) |-> (sr1[S1_RRDY] && cr1[C1_RRDY_IE]));
  a_r9_rx_term_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (sr1[S1_RRDY] && cr1[C1_RRDY_IE]) |-> irq);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] wd;
  logic             wr, rd;
  logic [REG_W-1:0] cr1, cr2, cr3, fcr, bmod, bcnt, msec;
  logic [REG_W-1:0] sr1_q, sr2_q, sr1_v, sr2_v, tst_v, hold;
  logic             full, accept, take, soft_rst, tx_fire;
  logic             unused_bits;

  assign idx = req_addr[ADDR_W-1:2];
  assign wd  = req_wdata[REG_W-1:0];
  assign wr  = req_valid & req_write;
  assign rd  = req_valid & ~req_write;
  assign unused_bits = ^{req_addr[1:0], req_wdata[DATA_W-1:REG_W]};

  function automatic logic hit(input logic [IDX_W-1:0] i, input int unsigned ix);
    return i == IDX_W'(ix);
  endfunction

  assign soft_rst = wr & hit(idx, IX_CR2) & ~wd[C2_SRST];
  assign tx_fire  = wr & hit(idx, IX_TXD) & cr2[C2_TXEN];
  assign take     = rd & hit(idx, IX_RXD) & full;

  // control and plain storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr1  <= '0;
      cr2  <= REG_W'(1) << C2_SRST;
      cr3  <= CR3_INIT;
      fcr  <= '0;
      bmod <= '0;
      bcnt <= BCNT_INIT;
      msec <= '0;
    end else if (wr) begin
      if (soft_rst) begin
        cr1  <= '0;
        cr3  <= CR3_INIT;
        bmod <= '0;
        bcnt <= BCNT_INIT;
      end
      if (hit(idx, IX_CR1))  cr1  <= wd;
      if (hit(idx, IX_CR2))  cr2  <= wd | (REG_W'(1) << C2_SRST);
      if (hit(idx, IX_CR3))  cr3  <= wd;
      if (hit(idx, IX_FCR))  fcr  <= wd;
      if (hit(idx, IX_BINC)) bcnt <= wd;
      if (hit(idx, IX_BMOD)) bmod <= wd;
      if (hit(idx, IX_MSEC)) msec <= wd;
    end
  end

  uart_rf_rxhold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .take(take), .full(full), .accept(accept), .hold(hold)
  );

  uart_rf_status #(.BYTE_W(BYTE_W)) u_st (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_sr1(wr & hit(idx, IX_SR1)), .wr_sr2(wr & hit(idx, IX_SR2)),
    .wdata(wd), .tx_fire(tx_fire), .tx_data(wd[BYTE_W-1:0]),
    .sr1_q(sr1_q), .sr2_q(sr2_q), .tx_strobe(tx_strobe), .tx_byte(tx_byte)
  );

  // status views: receive flags follow the holder
  always_comb begin
    sr1_v = sr1_q;
    sr1_v[S1_RRDY] = full;
    sr2_v = sr2_q;
    sr2_v[S2_RDR] = full;
    tst_v = '0;
    tst_v[T_RXEMPTY] = ~full;
    tst_v[T_TXEMPTY] = 1'b1;
  end

  uart_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sr1(sr1_v), .cr1(cr1), .tst(tst_v), .irq(irq)
  );

  assign rx_ready = ~full;

  // read mux
  always_comb begin
    logic [REG_W-1:0] r;
    r = '0;
    if (hit(idx, IX_RXD)) begin
      r = hold;
      r[RD_CHRDY] = full;
    end
    if (hit(idx, IX_CR1))  r = cr1;
    if (hit(idx, IX_CR2))  r = cr2;
    if (hit(idx, IX_CR3))  r = cr3;
    if (hit(idx, IX_FCR))  r = fcr;
    if (hit(idx, IX_SR1))  r = sr1_v;
    if (hit(idx, IX_SR2))  r = sr2_v;
    if (hit(idx, IX_BMOD)) r = bmod;
    if (hit(idx, IX_BCNT)) r = bcnt;
    if (hit(idx, IX_MSEC)) r = msec;
    if (hit(idx, IX_TEST)) r = tst_v;
    rd_data = DATA_W'(r);
  end

  a_r11_srst_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit(idx, IX_CR2)) |=> cr2[C2_SRST]);
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cr1 == '0 && bcnt == BCNT_INIT && !full && sr1_q == S1_INIT));
  a_r10_keeps_fifo_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(fcr) && $stable(msec));
  a_r4_ready_vs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> rx_ready);
endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
  logic [7:0]  rx_byte = '0, tx_byte;
  logic        tx_strobe, irq;
  int          checks = 0, errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  uart_regfront dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each task starts and ends at a falling edge and spans one cycle
  task automatic bus(input logic w, input int ix, input logic [31:0] d, output logic [31:0] r);
    req_valid = 1'b1; req_write = w; req_addr = 12'(ix << 2); req_wdata = d;
    #2 r = rd_data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, ix, d, dummy);
  endtask

  task automatic rd(input int ix, output logic [31:0] r);
    bus(1'b0, ix, 32'h0, r);
  endtask

  task automatic offer(input logic [7:0] b, input logic brk);
    rx_valid = 1'b1; rx_byte = b; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  function automatic logic [31:0] reset_view(input int ix, input logic [15:0] fcr_v,
                                             input logic [15:0] ms_v);
    case (ix)
      'h00: return 32'h4000;
      'h21: return 32'h0001;
      'h22: return 32'h0700;
      'h24: return {16'h0, fcr_v};
      'h25: return 32'h6040;
      'h26: return 32'h4028;
      'h2B: return 32'h0004;
      'h2C: return {16'h0, ms_v};
      'h2D: return 32'h0060;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq(input logic [15:0] c1, input logic full);
    logic rx_t, tx_t;
    rx_t = full && c1[9];
    tx_t = c1[13] || 1'b1;
    return rx_t || (c1[6] && tx_t);
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state over the whole decoded window, R1 map
    chk("R2 rx_ready", {31'h0, rx_ready}, 32'h1);
    chk("R2 irq", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 64; i++) begin
      rd(i, rv);
      chk($sformatf("R2 R1 reset read idx %0h", i), rv, reset_view(i, 16'h0, 16'h0));
    end

    // R1 R7 writes to every non-storage index have no effect
    for (int i = 0; i < 64; i++) begin
      if (i == 'h20 || i == 'h21 || i == 'h22 || i == 'h24 ||
          i == 'h29 || i == 'h2A || i == 'h2C) continue;
      wr(i, 32'hFFFF_FFFF);
      chk($sformatf("R8 no strobe idx %0h", i), {31'h0, tx_strobe}, 32'h0);
    end
    for (int i = 0; i < 64; i++) begin
      rd(i, rv);
      chk($sformatf("R7 R1 after junk idx %0h", i), rv, reset_view(i, 16'h0, 16'h0));
    end

    // R3 storage keeps low 16 bits
    wr('h24, 32'hABCD_1234); wr('h22, 32'h5555_0F0F);
    wr('h2A, 32'h1234_8001); wr('h2C, 32'hFFFF_7E7E); wr('h29, 32'h9999_00C3);
    rd('h24, rv); chk("R3 fifo ctrl", rv, 32'h1234);
    rd('h22, rv); chk("R3 ctrl3", rv, 32'h0F0F);
    rd('h2A, rv); chk("R3 modulator", rv, 32'h8001);
    rd('h2C, rv); chk("R3 millisecond", rv, 32'h7E7E);
    rd('h2B, rv); chk("R3 baud count via increment", rv, 32'h00C3);
    rd('h29, rv); chk("R1 increment reads zero", rv, 32'h0);

    // R11 control 2 storage
    wr('h21, 32'hFFFF_A5A7);
    rd('h21, rv); chk("R11 ctrl2 plain", rv, 32'hA5A7);

    // R4 receive path
    offer(8'h5A, 1'b0);
    chk("R4 rx_ready low", {31'h0, rx_ready}, 32'h0);
    rd('h25, rv); chk("R4 status1", rv, 32'h6240);
    rd('h26, rv); chk("R4 status2", rv, 32'h4029);
    rd('h2D, rv); chk("R4 test", rv, 32'h0040);
    offer(8'h33, 1'b0);
    // R6 read drains
    rd('h00, rv); chk("R6 R4 first read", rv, 32'h805A);
    chk("R6 rx_ready back", {31'h0, rx_ready}, 32'h1);
    rd('h00, rv); chk("R6 second read", rv, 32'h005A);
    rd('h25, rv); chk("R6 status1", rv, 32'h6040);
    rd('h2D, rv); chk("R6 test", rv, 32'h0060);

    // R5 break
    offer(8'hFF, 1'b1);
    rd('h00, rv); chk("R5 break marker", rv, 32'h8800);

    // R9 interrupt sweep over enables and holder state
    for (int f = 0; f < 2; f++) begin
      if (f == 1) offer(8'h11, 1'b0);
      for (int m = 0; m < 8; m++) begin
        logic [15:0] c1;
        c1 = 16'h0001;
        c1[6] = m[0]; c1[9] = m[1]; c1[13] = m[2];
        wr('h20, {16'hFFFF, c1});
        chk($sformatf("R9 irq c1=%h full=%0d", c1, f), {31'h0, irq},
            {31'h0, exp_irq(c1, f == 1)});
      end
    end
    rd('h00, rv); chk("R6 drain before tx", rv, 32'h8011);

    // R8 transmit
    wr('h20, 32'h0);
    wr('h21, 32'h0001);
    wr('h10, 32'h0000_01C7);
    chk("R8 disabled no strobe", {31'h0, tx_strobe}, 32'h0);
    wr('h21, 32'h0005);
    wr('h10, 32'h0000_01C7);
    chk("R8 strobe", {31'h0, tx_strobe}, 32'h1);
    chk("R8 byte", {24'h0, tx_byte}, 32'hC7);
    rd('h25, rv); chk("R8 ready low", rv, 32'h4040);
    chk("R8 strobe single", {31'h0, tx_strobe}, 32'h0);
    rd('h25, rv); chk("R8 ready back", rv, 32'h6040);

    // R10 soft reset
    wr('h20, 32'h0241); wr('h2A, 32'h7777); wr('h29, 32'h0099);
    offer(8'h42, 1'b0);
    wr('h21, 32'hFFFF_0006);
    chk("R10 rx_ready", {31'h0, rx_ready}, 32'h1);
    chk("R10 irq", {31'h0, irq}, 32'h0);
    rd('h21, rv); chk("R11 ctrl2 forced", rv, 32'h0007);
    for (int i = 0; i < 64; i++) begin
      if (i == 'h21) continue;
      rd(i, rv);
      chk($sformatf("R10 after soft reset idx %0h", i), rv, reset_view(i, 16'h1234, 16'h7E7E));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule